// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

The block holds eight timer channels, numbered 4 to 11 at the bus (index 0 to 7 inside). Each channel owns a 32-bit up-counter, a 32-bit compare value and a control word. A channel's counter advances on clock cycles where the tick-enable input picked by its control word is high. Channels can be grouped: a channel without its own-counter bit compares against the counter of its group leader (channel 4 for 4 to 7, channel 8 for 8 and 9, channel 10 for 10 and 11). Generating the tick rates is done outside the block.

A match raises a per-channel status bit when the matching enable bit is set. The eight status bits are ORed onto one interrupt line and are cleared from the common status register through a clear input. Each channel runs a two-state machine. In state ARMED a match can fire. The transition ARMED to SPENT is taken on a match when the periodic bit is clear. The transition SPENT to ARMED (and ARMED to ARMED) is taken on any bus write to that channel's compare or control register. A snapshot register captures the counter of channel 8 or 10 when the odd partner counter (9 or 11) is read with its snapshot bit set.

Bus reads return data in the same cycle as the address. Writes and snapshot captures take effect at the clock edge that ends the access.

Top module: `tmr_match_bank`

## Requirements
- R1: After reset every counter, compare value, control word, status bit and the snapshot read as zero, and `irq` is low.
- R2: Counters sit at offsets 0x40+4n, compare values at 0x80+4n and control words at 0xC0+4n (n = channel-4), and the snapshot sits at 0x20. Control words of channels 4 to 7 keep bits [7:0] of a write, and those of channels 8 to 11 keep bits [9:0]. All other offsets read zero.
- R3: Control bits [2:0] pick the rate. Values 1 to 5 select `tick[0]` to `tick[4]`, and values 0, 6 and 7 stop the counter. A running counter gains exactly one per cycle in which its selected tick is high.
- R4: A channel other than 4, 8 or 10 with control bit 7 clear has a stopped counter and compares against its leader's counter. With bit 7 set it counts and compares on its own counter. Leaders always count at their bits [2:0] rate.
- R5: On channels 8 to 11, control bit 8 set stops the channel's counter whatever bits [2:0] hold.
- R6: A match happens when the compared counter advances to the compare value while the channel is ARMED. It sets `status[n]` only if `ien[n]` is high. `irq` is the OR of `status`, and `clr[n]` clears `status[n]`.
- R7: With control bit 6 clear, a channel fires once and then ignores further matches until its compare or control register is written. With bit 6 set, it fires on every match.
- R8: With control bit 3 set, a match loads zero into the channel's own counter in place of the incremented value.
- R9: Reading counter 9 or 11 while that channel's control bit 9 is set copies counter 8 or 10 into the snapshot at the edge ending the read. Without bit 9 the snapshot is left unchanged.
- R10: A bus write to a counter takes priority over its increment and over reset-on-match.
- R11: When a match and `clr[n]` fall in the same cycle, `status[n]` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (drives snapshot capture) |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tick | input | 5 | Tick enables for rates 1 to 5 |
| ien | input | 8 | Interrupt enables for channels 4 to 11 |
| clr | input | 8 | Status clear for channels 4 to 11 |
| status | output | 8 | Per-channel match status |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong counter state shows up in the counter readback at the next read, and it shifts the cycle of the next match, so `status` rises a tick early or late. A channel's state machine stuck in the wrong state shows as a missing or repeated `status` rise within one match period of the control write. A wrong snapshot capture shows up at the first read of offset 0x20 after the partner read. The bench sweeps every rate code against every tick line. It then drives group, one-shot, periodic and snapshot patterns and compares against counts it works out itself.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
    typedef enum logic {
        CH_ARMED = 1'b0,
        CH_SPENT = 1'b1
    } ch_state_e;

    localparam int CTL_BITS    = 10;
    localparam int CB_RESET    = 3;
    localparam int CB_PERIODIC = 6;
    localparam int CB_OWN      = 7;
    localparam int CB_HALT     = 8;
    localparam int CB_SNAP     = 9;

    function automatic int leader_of(input int idx);
        if (idx < 4)      return 0;
        else if (idx < 6) return 4;
        else              return 6;
    endfunction
endpackage

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
    parameter int NRATE = 5
) (
    input  logic [2:0]       rate,
    input  logic [NRATE-1:0] tick,
    output logic             adv
);
    always_comb begin
        adv = 1'b0;
        for (int k = 0; k < NRATE; k++) begin
            if (rate == 3'(k + 1)) adv = tick[k];
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NRATE     = 5,
    parameter int CTL_W     = 8,
    parameter bit IS_LEADER = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NRATE-1:0]    tick,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                cnt_wr,
    input  logic                match_wr,
    input  logic                ctl_wr,
    input  logic                ien,
    input  logic                clr,
    input  logic                lead_adv,
    input  logic [DATA_W-1:0]   lead_cnt,
    output logic                own_adv,
    output logic [DATA_W-1:0]   cnt,
    output logic [DATA_W-1:0]   match,
    output logic [CTL_BITS-1:0] ctl,
    output logic                status
);
    localparam logic [CTL_BITS-1:0] CTL_MASK = CTL_BITS'((1 << CTL_W) - 1);

    ch_state_e            st_q, st_d;
    logic [DATA_W-1:0]    cnt_q, match_q;
    logic [CTL_BITS-1:0]  ctl_q;
    logic                 stat_q;
    logic [2:0]           eff_rate;
    logic                 src_adv, hit, rearm, use_own;
    logic [DATA_W-1:0]    src_cnt;

    assign use_own  = IS_LEADER || ctl_q[CB_OWN];
    assign eff_rate = (use_own && !ctl_q[CB_HALT]) ? ctl_q[2:0] : 3'd0;

    tmr_rate_sel #(.NRATE(NRATE)) u_rate (
        .rate (eff_rate),
        .tick (tick),
        .adv  (own_adv)
    );

    assign src_adv = use_own ? own_adv : lead_adv;
    assign src_cnt = use_own ? cnt_q   : lead_cnt;
    assign rearm   = match_wr || ctl_wr;
    assign hit     = (st_q == CH_ARMED) && src_adv && ((src_cnt + DATA_W'(1)) == match_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_ARMED;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_ARMED: if (!rearm && hit && !ctl_q[CB_PERIODIC]) st_d = CH_SPENT;
            CH_SPENT: if (rearm) st_d = CH_ARMED;
            default:  st_d = CH_ARMED;
        endcase
    end

    // Datapath outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= '0;
            ctl_q   <= '0;
            stat_q  <= 1'b0;
        end else begin
            if (cnt_wr)                        cnt_q <= wdata;
            else if (hit && ctl_q[CB_RESET])   cnt_q <= '0;
            else if (own_adv)                  cnt_q <= cnt_q + DATA_W'(1);
            if (match_wr) match_q <= wdata;
            if (ctl_wr)   ctl_q   <= wdata[CTL_BITS-1:0] & CTL_MASK;
            stat_q <= (stat_q && !clr) || (hit && ien);
        end
    end

    assign cnt    = cnt_q;
    assign match  = match_q;
    assign ctl    = ctl_q;
    assign status = stat_q;

    a_r6_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(hit && ien));
    a_r7_one_shot_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctl_q[CB_PERIODIC] && !rearm) |=> (st_q == CH_SPENT));
    a_r8_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctl_q[CB_RESET] && !cnt_wr) |=> (cnt_q == '0));
    a_r3_idle_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_adv && !cnt_wr && !(hit && ctl_q[CB_RESET])) |=> $stable(cnt_q));
    a_r5_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_HALT] && !cnt_wr && !(hit && ctl_q[CB_RESET])) |=> $stable(cnt_q));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
    import tmr_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRATE  = 5,
    parameter int NCH    = 8,
    parameter int NARROW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NRATE-1:0]  tick,
    input  logic [NCH-1:0]    ien,
    input  logic [NCH-1:0]    clr,
    output logic [NCH-1:0]    status,
    output logic              irq
);
    localparam int         IDX_W     = $clog2(NCH);
    localparam logic [7:0] SNAP_ADDR = 8'h20;
    localparam logic [1:0] RG_CNT    = 2'b01;
    localparam logic [1:0] RG_MATCH  = 2'b10;
    localparam logic [1:0] RG_CTL    = 2'b11;

    logic [DATA_W-1:0]   cnt_w   [NCH];
    logic [DATA_W-1:0]   match_w [NCH];
    logic [CTL_BITS-1:0] ctl_w   [NCH];
    logic [NCH-1:0]      adv_w;
    logic [DATA_W-1:0]   snap_q;

    logic [1:0]       region;
    logic [IDX_W-1:0] sel;
    logic             base_ok, snap_hit;

    assign region  = addr[7:6];
    assign sel     = addr[IDX_W+1:2];
    assign base_ok = !addr[5] && (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int LEAD = leader_of(i);
        logic hit_sel;
        assign hit_sel = base_ok && (sel == IDX_W'(i));
        tmr_channel #(
            .DATA_W    (DATA_W),
            .NRATE     (NRATE),
            .CTL_W     ((i < NARROW) ? 8 : 10),
            .IS_LEADER (LEAD == i)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wdata    (wdata),
            .cnt_wr   (wr_en && hit_sel && (region == RG_CNT)),
            .match_wr (wr_en && hit_sel && (region == RG_MATCH)),
            .ctl_wr   (wr_en && hit_sel && (region == RG_CTL)),
            .ien      (ien[i]),
            .clr      (clr[i]),
            .lead_adv (adv_w[LEAD]),
            .lead_cnt (cnt_w[LEAD]),
            .own_adv  (adv_w[i]),
            .cnt      (cnt_w[i]),
            .match    (match_w[i]),
            .ctl      (ctl_w[i]),
            .status   (status[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == SNAP_ADDR) begin
            rdata = snap_q;
        end else if (base_ok) begin
            case (region)
                RG_CNT:   rdata = cnt_w[sel];
                RG_MATCH: rdata = match_w[sel];
                RG_CTL:   rdata = DATA_W'(ctl_w[sel]);
                default:  rdata = '0;
            endcase
        end
    end

    assign snap_hit = rd_en && base_ok && (region == RG_CNT) && sel[0]
                      && (sel >= IDX_W'(NARROW)) && ctl_w[sel][CB_SNAP];

    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (snap_hit) snap_q <= cnt_w[sel - IDX_W'(1)];
    end

    assign irq = |status;

    a_r9_snap_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(snap_q));
    a_r6_irq_low_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) == {NCH{1'b1}}) && ($past(ien) == '0) |-> !irq);
endmodule

// File: tb/tmr_match_bank_test.sv
module tmr_match_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tick = '0;
    logic [7:0]  ien = '0, clr = '0;
    logic [7:0]  status;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_match_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .ien(ien), .clr(clr),
        .status(status), .irq(irq)
    );

    function automatic logic [7:0] a_cnt(int i);   return 8'(8'h40 + 4*i); endfunction
    function automatic logic [7:0] a_match(int i); return 8'(8'h80 + 4*i); endfunction
    function automatic logic [7:0] a_ctl(int i);   return 8'(8'hC0 + 4*i); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(int k, int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk); tick = 5'(1 << k);
            @(negedge clk); tick = '0;
        end
    endtask

    task automatic clr_all();
        @(negedge clk); clr = 8'hFF;
        @(negedge clk); clr = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(a_cnt(i), d);   check("R1 counter", d, 0);
            rd(a_match(i), d); check("R1 compare", d, 0);
            rd(a_ctl(i), d);   check("R1 control", d, 0);
        end
        rd(8'h20, d); check("R1 snapshot", d, 0);
        check("R1 status", {23'd0, irq, status}, 0);

        // R2 control width and compare storage, unmapped offsets
        for (int i = 0; i < 8; i++) begin
            wr(a_ctl(i), 32'hFFFF_FFFF);
            rd(a_ctl(i), d); check("R2 control width", d, (i < 4) ? 32'hFF : 32'h3FF);
            wr(a_ctl(i), 0);
            wr(a_match(i), 32'h1357_0000 + 32'(i));
            rd(a_match(i), d); check("R2 compare rw", d, 32'h1357_0000 + 32'(i));
            wr(a_match(i), 0);
        end
        rd(8'h00, d); check("R2 unmapped 0x00", d, 0);
        rd(8'h14, d); check("R2 unmapped 0x14", d, 0);
        rd(8'h42, d); check("R2 unaligned", d, 0);

        // R3 rate code x tick line sweep on channel 4
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 5; k++) begin
                wr(a_ctl(0), 32'h80 | 32'(r));
                wr(a_cnt(0), 0);
                pulse(k, 3);
                rd(a_cnt(0), d);
                check("R3 rate sweep", d, (r >= 1 && r <= 5 && r - 1 == k) ? 3 : 0);
            end
        end

        // R4 grouping: channel 5 follows counter 4
        wr(a_ctl(0), 32'h81); wr(a_cnt(0), 0);
        wr(a_ctl(1), 32'h01); wr(a_cnt(1), 0); wr(a_match(1), 5);
        ien = 8'h02;
        pulse(0, 5);
        rd(a_cnt(0), d); check("R4 leader counts", d, 5);
        rd(a_cnt(1), d); check("R4 member counter stopped", d, 0);
        check("R4 member matched leader", {24'd0, status}, 8'h02);
        check("R6 irq high", {31'd0, irq}, 1);
        clr_all();
        check("R6 clear", {23'd0, irq, status}, 0);
        wr(a_ctl(1), 32'h81);
        pulse(0, 2);
        rd(a_cnt(1), d); check("R4 own counter with bit 7", d, 2);
        ien = 8'h00;

        // R5 halt bit on channel 8, dropped on channel 4
        wr(a_ctl(4), 32'h101); wr(a_cnt(4), 0);
        pulse(0, 4);
        rd(a_cnt(4), d); check("R5 halt stops ch8", d, 0);
        wr(a_ctl(0), 32'h101); wr(a_cnt(0), 0);
        rd(a_ctl(0), d); check("R5 ch4 drops bit 8", d, 32'h01);
        pulse(0, 4);
        rd(a_cnt(0), d); check("R5 ch4 keeps counting", d, 4);

        // R6 enable gating
        wr(a_ctl(0), 32'h81); wr(a_cnt(0), 0); wr(a_match(0), 2);
        pulse(0, 2);
        check("R6 no status when disabled", {23'd0, irq, status}, 0);
        rd(a_cnt(0), d); check("R6 counter passes match w/o reset", d, 2);
        ien = 8'h01; wr(a_cnt(0), 0); wr(a_ctl(0), 32'h81);
        pulse(0, 2);
        check("R6 status when enabled", {23'd0, irq, status}, {23'd0, 1'b1, 8'h01});
        clr_all();

        // R7 / R8 one-shot then periodic, reset on match
        wr(a_ctl(0), 32'h89); wr(a_cnt(0), 0); wr(a_match(0), 3);
        pulse(0, 3);
        check("R7 one-shot fires", {24'd0, status}, 8'h01);
        rd(a_cnt(0), d); check("R8 counter zeroed", d, 0);
        clr_all();
        pulse(0, 3);
        check("R7 one-shot spent", {24'd0, status}, 0);
        rd(a_cnt(0), d); check("R8 spent: no reset", d, 3);
        wr(a_cnt(0), 0); wr(a_ctl(0), 32'hC9);
        for (int p = 0; p < 3; p++) begin
            pulse(0, 2);
            check("R7 periodic early", {24'd0, status}, 0);
            pulse(0, 1);
            check("R7 periodic fires", {24'd0, status}, 8'h01);
            clr_all();
        end

        // R11 set wins over clear
        wr(a_ctl(0), 32'hC9); wr(a_cnt(0), 0); wr(a_match(0), 1);
        @(negedge clk); tick = 5'b00001; clr = 8'h01;
        @(negedge clk); tick = '0; clr = '0;
        check("R11 set beats clear", {24'd0, status}, 8'h01);
        clr_all();
        ien = 8'h00;

        // R10 write beats increment
        @(negedge clk); addr = a_cnt(0); wdata = 100; wr_en = 1'b1; tick = 5'b00001;
        @(negedge clk); wr_en = 1'b0; tick = '0;
        rd(a_cnt(0), d); check("R10 write priority", d, 100);

        // R9 snapshot
        wr(a_ctl(4), 32'h81); wr(a_cnt(4), 0);
        pulse(0, 7);
        wr(a_ctl(5), 32'h200);
        rd(a_cnt(5), d);
        rd(8'h20, d); check("R9 snapshot of ch8", d, 7);
        pulse(0, 2);
        wr(a_ctl(7), 32'h000);
        rd(a_cnt(7), d);
        rd(8'h20, d); check("R9 no bit 9, unchanged", d, 7);
        rd(a_cnt(4), d);
        rd(8'h20, d); check("R9 leader read, unchanged", d, 7);
        wr(a_ctl(7), 32'h200);
        rd(a_cnt(7), d);
        rd(8'h20, d); check("R9 snapshot of ch10", d, 0);
        rd(a_cnt(5), d);
        rd(8'h20, d); check("R9 fresh ch8 value", d, 9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule